// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit takes the addressing fields of one decoded instruction and works out where its operand comes from. A 3-bit mode code selects the source. The source can be a general register or a constant from the instruction. It can also be a memory word, whose address is found from a single register plus a displacement, from a pair of adjacent registers plus a displacement, or from an absolute field. The unit reports the operand kind. For register and immediate sources it also gives the operand value. For memory sources it gives a 16-bit effective address and a flag that marks the address as usable.

The input and the output are valid/ready streams. Each input beat holds the mode, two register values, a 16-bit displacement/absolute field and a 16-bit immediate. A beat is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. Its result is registered and shows on the output on the next cycle. While `out_valid` is high and `out_ready` is low, the output is held unchanged and `in_ready` is low, so no new beat is accepted. When the output slot is empty or is draining in the same cycle, `in_ready` is high. This lets one beat per cycle flow with no bubble.

Top module: `eff_addr_gen`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: Mode 0 (register): `out_kind` = 0, `out_opnd` = `in_reg_a`, `out_addr` = 0, `out_addr_ok` = 0, `out_oor` = 0.
- R3: Mode 1 (immediate): `out_kind` = 1, `out_opnd` = `in_imm`, `out_addr` = 0, `out_addr_ok` = 0, `out_oor` = 0.
- R4: Mode 2 (register-relative): `out_kind` = 2, `out_addr` = (`in_reg_a` + `in_disp`) mod 65536, `out_addr_ok` = 1, `out_opnd` = 0. The displacement is a signed value.
- R5: Mode 3 (far pair): the 21-bit base is {`in_reg_b`[4:0], `in_reg_a`}, and bits 15:5 of `in_reg_b` are ignored. The base is added to the sign-extended displacement mod 2^21. `out_kind` = 2, `out_addr` = sum[15:0], `out_oor` = 1 if sum[20:16] is nonzero, and `out_addr_ok` = NOT `out_oor`.
- R6: Mode 4 (absolute): `out_kind` = 2, `out_addr` = `in_disp`, `out_addr_ok` = 1, `out_opnd` = 0.
- R7: Modes 5 to 7 are reserved: `out_kind` = 3, and `out_addr`, `out_opnd`, `out_addr_ok` and `out_oor` are all 0.
- R8: A beat accepted at one rising edge sets `out_valid` to 1 with its result immediately after that edge.
- R9: `in_ready` = NOT `out_valid` OR `out_ready`. While `out_valid` is high and `out_ready` is low, all outputs stay stable and an offered input beat is not taken.
- R10: `out_addr_ok` and `out_oor` are only ever 1 when `out_kind` = 2, and they are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat can be taken |
| in_mode | input | 3 | Addressing mode code |
| in_reg_a | input | 16 | Base register, or low half of the pair |
| in_reg_b | input | 16 | High register of the pair (bits 4:0 used) |
| in_disp | input | 16 | Signed displacement, or absolute address |
| in_imm | input | 16 | Immediate constant |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_kind | output | 2 | 0 register, 1 immediate, 2 memory, 3 reserved |
| out_addr | output | 16 | Effective address |
| out_addr_ok | output | 1 | Address usable |
| out_oor | output | 1 | Far sum beyond the low 64K |
| out_opnd | output | 16 | Register or immediate operand value |

## Verification
The hardest cases to reach are in the far-pair mode, at the edges of the 21-bit sum. One is a negative displacement that borrows across the 64K line and lands back inside it. Another is a sum that wraps past 2^21 to zero and so counts as in range. A third is a high register whose ignored upper bits are set. The vector table builds each of these from chosen pair values: base 0x10000 with -1, base 0x1FFFFF with +1, and high register 0xFFE0. Holding the output under back-pressure is reached by lowering `out_ready` and offering a second beat while the first is still waiting.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [1:0] {
    KIND_REG = 2'd0,
    KIND_IMM = 2'd1,
    KIND_MEM = 2'd2,
    KIND_BAD = 2'd3
  } opnd_kind_e;

  localparam logic [2:0] MODE_REG = 3'd0;
  localparam logic [2:0] MODE_IMM = 3'd1;
  localparam logic [2:0] MODE_REL = 3'd2;
  localparam logic [2:0] MODE_FAR = 3'd3;
  localparam logic [2:0] MODE_ABS = 3'd4;
endpackage

// File: rtl/eag_decode.sv
module eag_decode
  import eag_pkg::*;
(
  input  logic [2:0]  mode,
  output opnd_kind_e  kind,
  output logic        sel_rel,
  output logic        sel_far,
  output logic        sel_abs
);
  always_comb begin
    kind    = KIND_BAD;
    sel_rel = 1'b0;
    sel_far = 1'b0;
    sel_abs = 1'b0;
    case (mode)
      MODE_REG: kind = KIND_REG;
      MODE_IMM: kind = KIND_IMM;
      MODE_REL: begin kind = KIND_MEM; sel_rel = 1'b1; end
      MODE_FAR: begin kind = KIND_MEM; sel_far = 1'b1; end
      MODE_ABS: begin kind = KIND_MEM; sel_abs = 1'b1; end
      default:  kind = KIND_BAD;
    endcase
  end
endmodule

// File: rtl/eag_addr_calc.sv
module eag_addr_calc #(
  parameter int ADDR_W = 16,
  parameter int FAR_W  = 21
) (
  input  logic [ADDR_W-1:0] reg_a,
  input  logic [ADDR_W-1:0] reg_b,
  input  logic [ADDR_W-1:0] disp,
  output logic [ADDR_W-1:0] rel_addr,
  output logic [ADDR_W-1:0] far_addr,
  output logic              far_oor
);
  localparam int HI_W = FAR_W - ADDR_W;

  logic [FAR_W-1:0] far_base;
  logic [FAR_W-1:0] disp_ext;
  logic [FAR_W-1:0] far_sum;

  generate
    if (HI_W > 0) begin : g_pair
      assign far_base = {reg_b[HI_W-1:0], reg_a};
      assign disp_ext = {{HI_W{disp[ADDR_W-1]}}, disp};
      assign far_oor  = |far_sum[FAR_W-1:ADDR_W];
    end else begin : g_flat
      assign far_base = reg_a[FAR_W-1:0];
      assign disp_ext = disp[FAR_W-1:0];
      assign far_oor  = 1'b0;
    end
  endgenerate

  assign far_sum  = far_base + disp_ext;
  assign far_addr = far_sum[ADDR_W-1:0];
  assign rel_addr = reg_a + disp;
endmodule

// File: rtl/eag_out_stage.sv
module eag_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_valid && up_ready) begin
      dn_valid <= 1'b1;
      dn_data  <= up_data;
    end else if (dn_ready) begin
      dn_valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_data)); // R9
  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready |=> dn_valid); // R8
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int FAR_W  = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_mode,
  input  logic [ADDR_W-1:0] in_reg_a,
  input  logic [ADDR_W-1:0] in_reg_b,
  input  logic [ADDR_W-1:0] in_disp,
  input  logic [ADDR_W-1:0] in_imm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_addr_ok,
  output logic              out_oor,
  output logic [ADDR_W-1:0] out_opnd
);
  localparam int PW = 2 + 2 * ADDR_W + 2;

  opnd_kind_e        kind;
  logic              sel_rel, sel_far, sel_abs;
  logic [ADDR_W-1:0] rel_addr, far_addr;
  logic              far_oor;
  logic [ADDR_W-1:0] nx_addr, nx_opnd;
  logic              nx_ok, nx_oor;
  logic [PW-1:0]     nx_pack, q_pack;

  eag_decode u_dec (
    .mode(in_mode), .kind(kind),
    .sel_rel(sel_rel), .sel_far(sel_far), .sel_abs(sel_abs)
  );

  eag_addr_calc #(.ADDR_W(ADDR_W), .FAR_W(FAR_W)) u_calc (
    .reg_a(in_reg_a), .reg_b(in_reg_b), .disp(in_disp),
    .rel_addr(rel_addr), .far_addr(far_addr), .far_oor(far_oor)
  );

  always_comb begin
    nx_addr = '0;
    nx_opnd = '0;
    nx_ok   = 1'b0;
    nx_oor  = 1'b0;
    if (sel_rel) begin
      nx_addr = rel_addr;
      nx_ok   = 1'b1;
    end else if (sel_far) begin
      nx_addr = far_addr;
      nx_oor  = far_oor;
      nx_ok   = !far_oor;
    end else if (sel_abs) begin
      nx_addr = in_disp;
      nx_ok   = 1'b1;
    end else if (kind == KIND_REG) begin
      nx_opnd = in_reg_a;
    end else if (kind == KIND_IMM) begin
      nx_opnd = in_imm;
    end
  end

  assign nx_pack = {kind, nx_addr, nx_opnd, nx_ok, nx_oor};

  eag_out_stage #(.W(PW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(nx_pack),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(q_pack)
  );

  assign {out_kind, out_addr, out_opnd, out_addr_ok, out_oor} = q_pack;

  AST_FLAGS_MEM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_addr_ok || out_oor) |-> out_kind == KIND_MEM); // R10
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_addr_ok && out_oor)); // R10
  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == KIND_BAD |-> out_addr == '0 && out_opnd == '0); // R7
  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready)); // R9
endmodule

// File: tb/tb_eff_addr_gen.sv
module tb_eff_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_mode = '0;
  logic [15:0] in_reg_a = '0, in_reg_b = '0, in_disp = '0, in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_kind;
  logic [15:0] out_addr, out_opnd;
  logic        out_addr_ok, out_oor;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  eff_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_reg_a(in_reg_a), .in_reg_b(in_reg_b),
    .in_disp(in_disp), .in_imm(in_imm), .out_valid(out_valid),
    .out_ready(out_ready), .out_kind(out_kind), .out_addr(out_addr),
    .out_addr_ok(out_addr_ok), .out_oor(out_oor), .out_opnd(out_opnd)
  );

  // mode a b disp imm | kind addr opnd ok oor
  localparam int NV = 13;
  localparam logic [102:0] VEC [NV] = '{
    {3'd0, 16'h1234, 16'h0000, 16'h0000, 16'h5555, 2'd0, 16'h0000, 16'h1234, 1'b0, 1'b0},
    {3'd1, 16'h1234, 16'h0000, 16'h0000, 16'hBEEF, 2'd1, 16'h0000, 16'hBEEF, 1'b0, 1'b0},
    {3'd2, 16'h1000, 16'h0000, 16'h0010, 16'h0000, 2'd2, 16'h1010, 16'h0000, 1'b1, 1'b0},
    {3'd2, 16'h1000, 16'h0000, 16'hFFFF, 16'h0000, 2'd2, 16'h0FFF, 16'h0000, 1'b1, 1'b0},
    {3'd2, 16'hFFF0, 16'h0000, 16'h0020, 16'h0000, 2'd2, 16'h0010, 16'h0000, 1'b1, 1'b0},
    {3'd3, 16'h1234, 16'h0000, 16'h0004, 16'h0000, 2'd2, 16'h1238, 16'h0000, 1'b1, 1'b0},
    {3'd3, 16'h0000, 16'h0001, 16'hFFFF, 16'h0000, 2'd2, 16'hFFFF, 16'h0000, 1'b1, 1'b0},
    {3'd3, 16'hFFFF, 16'h0000, 16'h0001, 16'h0000, 2'd2, 16'h0000, 16'h0000, 1'b0, 1'b1},
    {3'd3, 16'hFFFF, 16'h001F, 16'h0001, 16'h0000, 2'd2, 16'h0000, 16'h0000, 1'b1, 1'b0},
    {3'd3, 16'h0005, 16'hFFE0, 16'h0000, 16'h0000, 2'd2, 16'h0005, 16'h0000, 1'b1, 1'b0},
    {3'd4, 16'h1111, 16'h2222, 16'hABCD, 16'h3333, 2'd2, 16'hABCD, 16'h0000, 1'b1, 1'b0},
    {3'd5, 16'h0001, 16'h0000, 16'h0002, 16'h0003, 2'd3, 16'h0000, 16'h0000, 1'b0, 1'b0},
    {3'd7, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 2'd3, 16'h0000, 16'h0000, 1'b0, 1'b0}
  };

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [50:0] act, input logic [50:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [50:0] out_bits();
    return {out_valid, out_kind, out_addr, out_opnd, out_addr_ok, out_oor};
  endfunction

  task automatic drive(input logic [102:0] v);
    in_mode  = v[102:100];
    in_reg_a = v[99:84];
    in_reg_b = v[83:68];
    in_disp  = v[67:52];
    in_imm   = v[51:36];
  endtask

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(posedge clk);
    #1 check("R1", {49'd0, out_valid, in_ready}, {49'd0, 1'b0, 1'b1});
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 check("R1", {49'd0, out_valid, in_ready}, {49'd0, 1'b0, 1'b1});

    // table walk, one beat per cycle, R8 latency
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      in_valid  = 1'b1;
      out_ready = 1'b1;
      @(posedge clk);
      #1 check(tag_of(VEC[i][102:100]), out_bits(), {1'b1, VEC[i][35:0], 14'd0} >> 14);
      check("R10", {49'd0, out_addr_ok, out_oor}, {49'd0, 1'b0, 1'b0} | {49'd0, VEC[i][1:0]});
    end

    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    #1 check("R8", {50'd0, out_valid}, 51'd0);

    // R9: back-pressure
    @(negedge clk);
    drive(VEC[2]);
    in_valid  = 1'b1;
    out_ready = 1'b0;
    @(posedge clk);
    #1 check("R8", out_bits(), {1'b1, VEC[2][35:0], 14'd0} >> 14);
    check("R9", {50'd0, in_ready}, 51'd0);
    @(negedge clk);
    drive(VEC[10]);
    @(posedge clk);
    #1 check("R9", out_bits(), {1'b1, VEC[2][35:0], 14'd0} >> 14);
    @(posedge clk);
    #1 check("R9", out_bits(), {1'b1, VEC[2][35:0], 14'd0} >> 14);
    @(negedge clk);
    out_ready = 1'b1;
    #1 check("R9", {50'd0, in_ready}, 51'd1);
    @(posedge clk);
    #1 check("R9", out_bits(), {1'b1, VEC[10][35:0], 14'd0} >> 14);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    #1 check("R9", {50'd0, out_valid}, 51'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule